// File: doc/BRIEF.md
# Dual-Channel Second-Order Bitstream Modulator

This block is a cycle-accurate digital model of a pair of second-order, single-bit delta-sigma modulators. Each channel receives a signed fixed-point sample that represents its differential input. A chain of two saturating integrators, a sign comparator and a two-level feedback value turn that sample into a serial stream of ones and zeros. The running average of the stream tracks the input.

Everything runs on one fast system clock. A rate source is picked by a select pin: either an enable pulse supplied from outside, or an internal enable that fires every `INT_PERIOD` system cycles. Each pulse from the chosen source toggles a divide-by-two register. That register is driven out as the bit clock both channels share. Both channels take their samples and update their output bits in the same system cycle, the one in which the bit clock rises. A downstream decimation filter therefore samples both streams against one clock.

The feedback level is set to 23/21 of the input full scale. With that scaling, an input at +92 % of full scale gives 92 % ones and an input at −92 % gives 8 % ones.

Top module: `dsm_dual_mod`

## Requirements
- R1: `bit_clk` inverts in the system cycle after each pulse of the selected rate source, and holds in every other cycle. Its period is therefore two source pulses and its high time one source pulse.
- R2: With `clk_sel` = 0 the source is `ext_tick`. With `clk_sel` = 1 the source is an internal enable that fires once every `INT_PERIOD` system cycles (default 2), and `ext_tick` has no effect. With `clk_sel` = 0 and `ext_tick` held low, neither `bit_clk` nor the data outputs change.
- R3: `bit_a` and `bit_b` change only in the system cycle in which `bit_clk` rises. Each value is held for one full bit period.
- R4: While `rst_n` is low, `bit_clk`, `bit_a` and `bit_b` are 0 and both integrators are cleared. The first bit produced after reset is 0 on both channels, whatever the input.
- R5: Output 1 means the second integrator was strictly positive. The feedback is +REF after a 1 and −REF after a 0, with REF = floor(2^(IN_W−1)·23/21) (35888 at the default width). The ones-density over a long run is 1/2 + x/(2·REF); a zero input gives 50 %.
- R6: A sample of +30147 (+92 % of full scale at the default width) gives about 92 % ones, and −30147 gives about 8 %. Over 4096 bits the count stays within ±1 % of the expected value.
- R7: The two channels are independent. Different samples on `sample_a` and `sample_b` in the same window each produce their own expected density.
- R8: The integrators saturate and never wrap. Per step, the first integrator changes by at most 2^(IN_W−1)+REF, and the second never jumps from above +2^(ACC_W−2) to below −2^(ACC_W−2). After a stretch at extreme full-scale input, a zero input again gives 50 % ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all state is updated on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously by the driver |
| clk_sel | input | 1 | Rate source select: 0 = external enable, 1 = internal enable |
| ext_tick | input | 1 | External rate enable, one cycle wide per external clock edge |
| sample_a | input | IN_W | Signed input sample of channel A |
| sample_b | input | IN_W | Signed input sample of channel B |
| bit_clk | output | 1 | Shared bit clock, selected source divided by two |
| bit_a | output | 1 | Bitstream output of channel A |
| bit_b | output | 1 | Bitstream output of channel B |

## Verification
`bit_clk` reacts one system cycle after a source pulse. The data bits change in that same cycle, and only when `bit_clk` goes from 0 to 1. The bench therefore samples every output on the falling system edge and treats a 0-to-1 step of `bit_clk` between two samples as one new bit. After each change of input, a density result is due 128 bits of settling plus a 4096-bit counting window later. The driver pushes the expected counts only once the settling bits have passed. The monitor pops them after exactly 4096 new bits. Period, hold and first-bit checks use counts of falling system edges measured from known points.

// File: rtl/dsm_pkg.sv
`timescale 1ns/1ps
package dsm_pkg;

  // Rate source encoding on the select pin
  typedef enum logic {
    SRC_EXT = 1'b0,
    SRC_INT = 1'b1
  } clk_src_e;

  // Feedback magnitude: full scale of an in_w-bit sample times num/den
  function automatic int fb_level(input int in_w, input int num, input int den);
    return ((1 << (in_w - 1)) * num) / den;
  endfunction

endpackage

// File: rtl/dsm_clkgen.sv
`timescale 1ns/1ps
module dsm_clkgen #(
  parameter int INT_PERIOD = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clk_sel,
  input  logic ext_tick,
  output logic bit_clk,
  output logic step
);
  import dsm_pkg::*;

  localparam int CNT_W = (INT_PERIOD > 1) ? $clog2(INT_PERIOD) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(INT_PERIOD - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             int_tick;
  logic             src_tick;
  logic             bclk_q, bclk_d;

  // Internal enable source: one pulse every INT_PERIOD cycles
  generate
    if (INT_PERIOD > 1) begin : g_int_div
      always_comb begin
        int_tick = (cnt_q == CNT_LAST);
        cnt_d    = int_tick ? '0 : cnt_q + 1'b1;
      end
    end else begin : g_int_free
      always_comb begin
        int_tick = 1'b1;
        cnt_d    = cnt_q;
      end
    end
  endgenerate

  // Source select, divide-by-two and modulator step strobe
  always_comb begin
    src_tick = (clk_src_e'(clk_sel) == SRC_INT) ? int_tick : ext_tick;
    bclk_d   = bclk_q ^ src_tick;
    step     = src_tick & ~bclk_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      bclk_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      bclk_q <= bclk_d;
    end
  end

  assign bit_clk = bclk_q;

endmodule

// File: rtl/dsm_integ.sv
`timescale 1ns/1ps
module dsm_integ #(
  parameter int ACC_W = 23
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  logic signed [ACC_W:0]   inc,
  output logic signed [ACC_W-1:0] acc
);
  localparam int SUM_W = ACC_W + 2;
  localparam logic signed [SUM_W-1:0] ACC_HI = {3'b000, {(ACC_W-1){1'b1}}};
  localparam logic signed [SUM_W-1:0] ACC_LO = {3'b111, {(ACC_W-1){1'b0}}};

  logic signed [ACC_W-1:0] acc_q, acc_d;
  logic signed [SUM_W-1:0] sum;

  always_comb begin
    sum = {{2{acc_q[ACC_W-1]}}, acc_q} + {inc[ACC_W], inc};
    if (!en) begin
      acc_d = acc_q;
    end else if (sum > ACC_HI) begin
      acc_d = ACC_HI[ACC_W-1:0];
    end else if (sum < ACC_LO) begin
      acc_d = ACC_LO[ACC_W-1:0];
    end else begin
      acc_d = sum[ACC_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  assign acc = acc_q;

endmodule

// File: rtl/dsm_channel.sv
`timescale 1ns/1ps
module dsm_channel #(
  parameter int IN_W  = 16,
  parameter int ACC_W = 23,
  parameter int REF   = 35888
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    step,
  input  logic signed [IN_W-1:0]  sample,
  output logic                    bit_o,
  output logic signed [ACC_W-1:0] int1,
  output logic signed [ACC_W-1:0] int2
);
  localparam int NSTAGE = 2;
  localparam logic signed [ACC_W:0] REF_POS = (ACC_W+1)'(REF);
  localparam logic signed [ACC_W:0] REF_NEG = -REF_POS;

  logic signed [ACC_W:0]   inc [NSTAGE];
  logic signed [ACC_W-1:0] acc [NSTAGE];
  logic signed [ACC_W:0]   fb;
  logic signed [ACC_W:0]   samp_ext;
  logic                    cmp;
  logic                    bit_q, bit_d;

  // Comparator on the second integrator; zero counts as low
  always_comb begin
    cmp = !acc[1][ACC_W-1] && (acc[1] != '0);
    fb  = cmp ? REF_POS : REF_NEG;
  end

  // Stage inputs: input minus feedback, then stage-1 state minus twice feedback
  always_comb begin
    samp_ext = {{(ACC_W+1-IN_W){sample[IN_W-1]}}, sample};
    inc[0]   = samp_ext - fb;
    inc[1]   = {acc[0][ACC_W-1], acc[0]} - (fb <<< 1);
  end

  generate
    for (genvar s = 0; s < NSTAGE; s++) begin : g_stage
      dsm_integ #(.ACC_W(ACC_W)) u_integ (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (step),
        .inc   (inc[s]),
        .acc   (acc[s])
      );
    end
  endgenerate

  // Output bit register: captures the comparator on each step
  always_comb bit_d = step ? cmp : bit_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bit_q <= 1'b0;
    else        bit_q <= bit_d;
  end

  assign bit_o = bit_q;
  assign int1  = acc[0];
  assign int2  = acc[1];

endmodule

// File: rtl/dsm_dual_mod.sv
`timescale 1ns/1ps
module dsm_dual_mod #(
  parameter int IN_W       = 16,
  parameter int GUARD      = 6,
  parameter int INT_PERIOD = 2,
  parameter int REF_NUM    = 23,
  parameter int REF_DEN    = 21
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clk_sel,
  input  logic            ext_tick,
  input  logic [IN_W-1:0] sample_a,
  input  logic [IN_W-1:0] sample_b,
  output logic            bit_clk,
  output logic            bit_a,
  output logic            bit_b
);
  localparam int NCH   = 2;
  localparam int ACC_W = IN_W + 1 + GUARD;
  localparam int REF   = dsm_pkg::fb_level(IN_W, REF_NUM, REF_DEN);

  logic                    step;
  logic signed [IN_W-1:0]  smp  [NCH];
  logic                    bits [NCH];
  logic [NCH*ACC_W-1:0]    int1_flat;
  logic [NCH*ACC_W-1:0]    int2_flat;

  assign smp[0] = sample_a;
  assign smp[1] = sample_b;

  dsm_clkgen #(.INT_PERIOD(INT_PERIOD)) u_clkgen (
    .clk      (clk),
    .rst_n    (rst_n),
    .clk_sel  (clk_sel),
    .ext_tick (ext_tick),
    .bit_clk  (bit_clk),
    .step     (step)
  );

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_ch
      logic signed [ACC_W-1:0] i1, i2;
      dsm_channel #(.IN_W(IN_W), .ACC_W(ACC_W), .REF(REF)) u_ch (
        .clk    (clk),
        .rst_n  (rst_n),
        .step   (step),
        .sample (smp[c]),
        .bit_o  (bits[c]),
        .int1   (i1),
        .int2   (i2)
      );
      assign int1_flat[c*ACC_W +: ACC_W] = i1;
      assign int2_flat[c*ACC_W +: ACC_W] = i2;
    end
  endgenerate

  assign bit_a = bits[0];
  assign bit_b = bits[1];

endmodule

// File: rtl/dsm_dual_mod_chk.sv
`timescale 1ns/1ps
module dsm_dual_mod_chk #(
  parameter int NCH   = 2,
  parameter int IN_W  = 16,
  parameter int ACC_W = 23,
  parameter int REF   = 35888
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 clk_sel,
  input logic                 ext_tick,
  input logic                 bit_clk,
  input logic                 bit_a,
  input logic                 bit_b,
  input logic [NCH*ACC_W-1:0] int1_flat,
  input logic [NCH*ACC_W-1:0] int2_flat
);
  localparam int STEP1 = (1 << (IN_W - 1)) + REF;
  localparam int QTR   = 1 << (ACC_W - 2);

  // R1
  ext_idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_sel && !ext_tick) |=> $stable(bit_clk));

  // R1
  ext_tick_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_sel && ext_tick) |=> (bit_clk != $past(bit_clk)));

  // R3
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(bit_clk) |-> ($stable(bit_a) && $stable(bit_b)));

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_ch
      logic signed [ACC_W-1:0] cur1, cur2, prev1_q, prev2_q;
      logic signed [ACC_W+1:0] d1;

      assign cur1 = int1_flat[c*ACC_W +: ACC_W];
      assign cur2 = int2_flat[c*ACC_W +: ACC_W];
      assign d1   = {{2{cur1[ACC_W-1]}}, cur1} - {{2{prev1_q[ACC_W-1]}}, prev1_q};

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          prev1_q <= '0;
          prev2_q <= '0;
        end else begin
          prev1_q <= cur1;
          prev2_q <= cur2;
        end
      end

      // R8
      int1_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (d1 <= STEP1) && (d1 >= -STEP1));

      // R8
      int2_nowrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !((prev2_q > QTR) && (cur2 < -QTR)));
    end
  endgenerate

endmodule

bind dsm_dual_mod dsm_dual_mod_chk #(
  .NCH   (NCH),
  .IN_W  (IN_W),
  .ACC_W (ACC_W),
  .REF   (REF)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .clk_sel   (clk_sel),
  .ext_tick  (ext_tick),
  .bit_clk   (bit_clk),
  .bit_a     (bit_a),
  .bit_b     (bit_b),
  .int1_flat (int1_flat),
  .int2_flat (int2_flat)
);

// File: tb/dsm_dual_mod_bench.sv
`timescale 1ns/1ps
module dsm_dual_mod_bench;
  localparam int IN_W     = 16;
  localparam int INT_PER  = 2;
  localparam int WIN      = 4096;
  localparam int SETTLE   = 128;
  localparam int TOL      = 41;
  localparam int REFB     = ((1 << (IN_W - 1)) * 23) / 21;
  localparam int WD_CYC   = 190000;
  localparam int P92      = 30147;

  typedef struct {
    int    exp_a;
    int    exp_b;
    string tag;
  } win_t;

  logic            clk      = 1'b0;
  logic            rst_n    = 1'b0;
  logic            clk_sel  = 1'b1;
  logic            ext_tick = 1'b0;
  logic [IN_W-1:0] sample_a = '0;
  logic [IN_W-1:0] sample_b = '0;
  logic            bit_clk, bit_a, bit_b;

  int   n_checks    = 0;
  int   n_fails     = 0;
  int   bits_seen   = 0;
  int   wins_done   = 0;
  int   r3_viol     = 0;
  int   win_n       = 0;
  int   ones_a      = 0;
  int   ones_b      = 0;
  bit   ext_run     = 1'b0;
  int   ext_cnt     = 0;
  logic bclk_prev   = 1'b0;
  logic a_prev      = 1'b0;
  logic b_prev      = 1'b0;
  bit   done        = 1'b0;
  win_t sb_q[$];

  always #4 clk = ~clk;

  dsm_dual_mod u_dsm_dual_mod (
    .clk      (clk),
    .rst_n    (rst_n),
    .clk_sel  (clk_sel),
    .ext_tick (ext_tick),
    .sample_a (sample_a),
    .sample_b (sample_b),
    .bit_clk  (bit_clk),
    .bit_a    (bit_a),
    .bit_b    (bit_b)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_ones(input int x);
    return $rtoi(real'(WIN) * (0.5 + real'(x) / (2.0 * real'(REFB))) + 0.5);
  endfunction

  // External enable generator: one pulse every third cycle while running
  always @(negedge clk) begin
    if (ext_run) begin
      ext_cnt  = (ext_cnt == 2) ? 0 : ext_cnt + 1;
      ext_tick = (ext_cnt == 0);
    end else begin
      ext_tick = 1'b0;
    end
  end

  // Monitor: detects new bits, checks R3 holds, runs the density scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (bit_clk && !bclk_prev) begin
        bits_seen++;
        if (sb_q.size() > 0) begin
          win_n++;
          ones_a += int'(bit_a);
          ones_b += int'(bit_b);
          if (win_n == WIN) begin
            check((ones_a >= sb_q[0].exp_a - TOL) && (ones_a <= sb_q[0].exp_a + TOL),
                  {sb_q[0].tag, " ch A ones"}, ones_a, sb_q[0].exp_a);
            check((ones_b >= sb_q[0].exp_b - TOL) && (ones_b <= sb_q[0].exp_b + TOL),
                  {sb_q[0].tag, " ch B ones"}, ones_b, sb_q[0].exp_b);
            void'(sb_q.pop_front());
            win_n  = 0;
            ones_a = 0;
            ones_b = 0;
            wins_done++;
          end
        end
      end else if ((bit_a != a_prev) || (bit_b != b_prev)) begin
        r3_viol++;
      end
    end
    bclk_prev = bit_clk;
    a_prev    = bit_a;
    b_prev    = bit_b;
  end

  // Driver: apply samples, let the loop settle, push expectations, wait for the window
  task automatic run_window(input int xa, input int xb, input string tag);
    int target;
    int wdone;
    @(negedge clk);
    sample_a = IN_W'(xa);
    sample_b = IN_W'(xb);
    target = bits_seen + SETTLE;
    wait (bits_seen >= target);
    wdone = wins_done + 1;
    sb_q.push_back('{exp_a: exp_ones(xa), exp_b: exp_ones(xb), tag: tag});
    wait (wins_done >= wdone);
  endtask

  // Records bit_clk over 40 falling edges; returns rise-to-rise period and high time
  task automatic measure_bclk(output int per, output int hi);
    logic h [40];
    int   r0, r1, f0;
    r0 = -1; r1 = -1; f0 = -1;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      h[i] = bit_clk;
    end
    for (int i = 1; i < 40; i++) begin
      if (h[i] && !h[i-1]) begin
        if (r0 < 0) r0 = i;
        else if (r1 < 0) r1 = i;
      end
      if (!h[i] && h[i-1] && r0 >= 0 && f0 < 0) f0 = i;
    end
    per = r1 - r0;
    hi  = f0 - r0;
  endtask

  initial begin
    int per, hi, bs;
    logic hb, ha, hbb;
    int   moved;

    // R4: reset state
    repeat (5) @(negedge clk);
    check(!bit_clk && !bit_a && !bit_b, "R4 reset outputs", {bit_clk, bit_a, bit_b}, 0);

    // R4: first bit after release is 0 even with a large input applied
    sample_a = IN_W'(P92);
    sample_b = IN_W'(-P92);
    @(negedge clk);
    rst_n = 1'b1;
    wait (bits_seen >= 1);
    check(!bit_a && !bit_b, "R4 first bit", {bit_a, bit_b}, 0);

    // R1 R2: internal source, period 2*INT_PER, high INT_PER
    measure_bclk(per, hi);
    check(per == 2 * INT_PER, "R2 internal bit_clk period", per, 2 * INT_PER);
    check(hi == INT_PER, "R1 internal bit_clk high time", hi, INT_PER);

    // R5: zero input gives half ones
    run_window(0, 0, "R5 zero");
    // R6 R7: +92% and -92% on separate channels at once
    run_window(P92, -P92, "R6 R7 +92/-92");
    // R5 R7: other levels
    run_window(16384, -24576, "R5 R7 mid levels");
    // R6: swapped polarity
    run_window(-P92, P92, "R6 swapped");

    // R8: extreme inputs, then zero must give half ones again
    @(negedge clk);
    sample_a = IN_W'(32767);
    sample_b = IN_W'(-32768);
    bs = bits_seen + 1024;
    wait (bits_seen >= bs);
    run_window(0, 0, "R8 recovery");

    // R1 R2: external source with a pulse every third cycle
    @(negedge clk);
    clk_sel = 1'b0;
    ext_run = 1'b1;
    measure_bclk(per, hi);
    check(per == 6, "R1 external bit_clk period", per, 6);
    check(hi == 3, "R1 external bit_clk high time", hi, 3);

    // R2: external selected and idle -> nothing moves though internal source runs
    ext_run = 1'b0;
    @(negedge clk);
    @(negedge clk);
    hb = bit_clk; ha = bit_a; hbb = bit_b;
    moved = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (bit_clk != hb || bit_a != ha || bit_b != hbb) moved++;
    end
    check(moved == 0, "R2 idle external source hold", moved, 0);

    // R3: data changed only on bit_clk rise during the whole run
    check(r3_viol == 0, "R3 data outside bit_clk rise", r3_viol, 0);

    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    #(WD_CYC * 8);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fails++;
      $display("FAIL R1 watchdog actual=%0d bits expected=run complete", bits_seen);
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

endmodule